// File: doc/BRIEF.md
# Advertising Event Channel Sequencer

This block schedules the advertising events of a short-range radio. It counts a microsecond tick and opens an event once per programmed interval. Within an event it steps upward through whichever of the three advertising channels the host has enabled. On each channel it raises a one-cycle transmit strobe and then holds that channel for the airtime of the packet. The airtime follows from the payload length. When scan responses are enabled, every advertising packet is followed by a listen window on the same channel. A scan request that arrives inside that window is answered with a response strobe on that channel, a fixed gap after the request ended. The walk then moves on.

The host drives the configuration pins, a run enable and an abort input. The radio drives the scan-request pulse. Modulation, framing and CRC live in the radio datapath, which takes the channel index and strobes from this block. There is no data stream at the edge of this block: every pin is a plain control or status level, or a single-cycle pulse. Nothing applies back-pressure. The radio must accept each strobe in the cycle it is raised.

Top module: `adv_event_seq`

## Requirements
- R1: Mask bit 0 enables channel 37, bit 1 enables channel 38 and bit 2 enables channel 39. `chan_idx` carries the channel number itself. Within an event, the enabled channels each get one advertising strobe, in ascending order.
- R2: Every event, including one that follows an abort, begins on the lowest enabled channel.
- R3: With a valid configuration and `adv_en` high, event starts are spaced exactly `cfg_interval_ms` × TICKS_PER_MS ticks apart.
- R4: `cfg_err` rises one cycle after any of these holds: the mask is zero, the payload length is above 31, or the interval is outside 20..10240. While `cfg_err` is high, no event runs and any running event is closed.
- R5: An advertising packet, and a scan response, occupies (OVH_BYTES + `cfg_payload_len`) × 8 ticks. With scan responses off, consecutive strobes in an event are exactly that far apart, and each strobe lasts one cycle.
- R6: With `cfg_scan_rsp_en` high, each advertising packet is followed by LISTEN_TICKS ticks with `listen_win` high. If no request arrives, the next channel's strobe comes right after the window.
- R7: A `rx_scan_req` pulse sampled during the listen window produces a strobe with `tx_is_rsp` high, on the same channel, exactly RSP_GAP_TICKS (150) ticks later. The next advertising strobe follows one packet airtime after that.
- R8: `abort_evt` closes the event at the next clock edge. No further strobe occurs until the next scheduled start.
- R9: `event_active` is high from the first strobe of an event until the last packet (or listen window) ends, and falls in the following cycle.
- R10: A start that falls due while an event is still running is held. It begins the next event, on the first enabled channel, as soon as the running event ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_us | input | 1 | One-microsecond tick enable |
| adv_en | input | 1 | Run the interval schedule |
| abort_evt | input | 1 | Close the running event at once |
| cfg_chan_mask | input | 3 | Enabled channels (bit0=37, bit1=38, bit2=39) |
| cfg_interval_ms | input | 14 | Advertising interval in milliseconds |
| cfg_payload_len | input | 6 | Payload length in bytes |
| cfg_scan_rsp_en | input | 1 | Open listen windows and answer requests |
| rx_scan_req | input | 1 | Pulse: a scan request just ended |
| chan_idx | output | 6 | Current channel number (37..39) |
| tx_strobe | output | 1 | One-cycle transmit start |
| tx_is_rsp | output | 1 | Qualifies tx_strobe as a scan response |
| listen_win | output | 1 | Listening for a scan request |
| event_active | output | 1 | An advertising event is in progress |
| cfg_err | output | 1 | Configuration rejected |

## Verification
The bench ties the tick high, so one tick equals one cycle. It counts rising edges and logs every strobe on the falling edge, together with its edge number, channel and kind. Each timing result is a difference of edge numbers. Packet-to-packet spacing must equal the airtime. A response is due 150 edges after the edge that sampled the request, and event starts are due one interval apart. Single-cycle results (`event_active` falling after an abort or after the last packet, and `cfg_err` rising) are sampled in the half-period after the exact edge computed from the register count: one register for each of these paths.

// File: rtl/adv_seq_pkg.sv
package adv_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_TX     = 3'd1,
    ST_LISTEN = 3'd2,
    ST_GAP    = 3'd3,
    ST_RSP    = 3'd4
  } seq_state_e;

  localparam int NUM_CH   = 3;
  localparam int CH_BASE  = 37;

  // lowest enabled channel position
  function automatic logic [1:0] first_chan(input logic [NUM_CH-1:0] m);
    logic [1:0] r;
    r = 2'd0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (m[i]) r = 2'(i);
    end
    return r;
  endfunction

  // {found, position} of the next enabled channel above p
  function automatic logic [2:0] next_chan(input logic [NUM_CH-1:0] m,
                                           input logic [1:0] p);
    logic [2:0] r;
    r = 3'b000;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (m[i] && (i > int'(p))) r = {1'b1, 2'(i)};
    end
    return r;
  endfunction

endpackage

// File: rtl/adv_cfg_check.sv
module adv_cfg_check #(
  parameter int INTV_W      = 14,
  parameter int LEN_W       = 6,
  parameter int MAX_PAYLOAD = 31,
  parameter int MIN_INTV    = 20,
  parameter int MAX_INTV    = 10240
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mask,
  input  logic [INTV_W-1:0] interval,
  input  logic [LEN_W-1:0]  payload_len,
  output logic              cfg_err
);
  localparam logic [INTV_W-1:0] LO_V  = INTV_W'(MIN_INTV);
  localparam logic [INTV_W-1:0] HI_V  = INTV_W'(MAX_INTV);
  localparam logic [LEN_W-1:0]  LEN_V = LEN_W'(MAX_PAYLOAD);

  logic bad;
  always_comb begin
    bad = (mask == 3'b000) || (payload_len > LEN_V) ||
          (interval < LO_V) || (interval > HI_V);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_err <= 1'b0;
    else        cfg_err <= bad;
  end
endmodule

// File: rtl/adv_interval_timer.sv
module adv_interval_timer #(
  parameter int TICKS_PER_MS = 1000,
  parameter int INTV_W       = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              run,
  input  logic [INTV_W-1:0] interval,
  output logic              start_evt
);
  localparam int SUB_W = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(TICKS_PER_MS - 1);

  logic              sched_on;
  logic [SUB_W-1:0]  sub_cnt;
  logic [INTV_W-1:0] ms_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sched_on  <= 1'b0;
      sub_cnt   <= '0;
      ms_cnt    <= '0;
      start_evt <= 1'b0;
    end else begin
      start_evt <= 1'b0;
      if (!run) begin
        sched_on <= 1'b0;
        sub_cnt  <= '0;
        ms_cnt   <= '0;
      end else if (!sched_on) begin
        sched_on  <= 1'b1;
        start_evt <= 1'b1;
        sub_cnt   <= '0;
        ms_cnt    <= '0;
      end else if (tick) begin
        if (sub_cnt == SUB_LAST) begin
          sub_cnt <= '0;
          if (ms_cnt == interval - 1'b1) begin
            ms_cnt    <= '0;
            start_evt <= 1'b1;
          end else begin
            ms_cnt <= ms_cnt + 1'b1;
          end
        end else begin
          sub_cnt <= sub_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/adv_event_fsm.sv
module adv_event_fsm
  import adv_seq_pkg::*;
#(
  parameter int LEN_W         = 6,
  parameter int CNT_W         = 12,
  parameter int OVH_BYTES     = 10,
  parameter int LISTEN_TICKS  = 300,
  parameter int RSP_GAP_TICKS = 150
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             start_evt,
  input  logic             kill,
  input  logic [2:0]       mask,
  input  logic [LEN_W-1:0] payload_len,
  input  logic             scan_en,
  input  logic             rx_req,
  output logic [1:0]       chan_pos,
  output logic             tx_strobe,
  output logic             tx_is_rsp,
  output logic             listen_win,
  output logic             event_active
);
  localparam logic [CNT_W-1:0] LISTEN_M1 = CNT_W'(LISTEN_TICKS - 1);
  localparam logic [CNT_W-1:0] GAP_M1    = CNT_W'(RSP_GAP_TICKS - 1);

  seq_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic             pend;
  logic [CNT_W-1:0] air_m1;
  logic [2:0]       nxt;
  logic [1:0]       first_pos;
  logic             go_tx;
  logic [1:0]       go_pos;

  always_comb begin
    air_m1    = CNT_W'((32'(payload_len) + OVH_BYTES) * 8 - 1);
    nxt       = next_chan(mask, chan_pos);
    first_pos = first_chan(mask);
    // where the walk goes once the current packet or window is over
    if (nxt[2]) begin
      go_tx  = 1'b1;
      go_pos = nxt[1:0];
    end else if (pend || start_evt) begin
      go_tx  = 1'b1;
      go_pos = first_pos;
    end else begin
      go_tx  = 1'b0;
      go_pos = chan_pos;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      pend      <= 1'b0;
      chan_pos  <= 2'd0;
      tx_strobe <= 1'b0;
      tx_is_rsp <= 1'b0;
    end else begin
      tx_strobe <= 1'b0;
      if (kill) begin
        state <= ST_IDLE;
        pend  <= 1'b0;
      end else begin
        if (start_evt && (state != ST_IDLE)) pend <= 1'b1;
        unique case (state)
          ST_IDLE: begin
            if (start_evt) begin
              state     <= ST_TX;
              chan_pos  <= first_pos;
              cnt       <= air_m1;
              tx_strobe <= 1'b1;
              tx_is_rsp <= 1'b0;
            end
          end
          ST_TX: begin
            if (tick) begin
              if (cnt != '0) begin
                cnt <= cnt - 1'b1;
              end else if (scan_en) begin
                state <= ST_LISTEN;
                cnt   <= LISTEN_M1;
              end else begin
                state    <= go_tx ? ST_TX : ST_IDLE;
                chan_pos <= go_pos;
                if (go_tx) begin
                  cnt       <= air_m1;
                  tx_strobe <= 1'b1;
                  tx_is_rsp <= 1'b0;
                end
                if (!nxt[2]) pend <= 1'b0;
              end
            end
          end
          ST_LISTEN: begin
            if (rx_req) begin
              state <= ST_GAP;
              cnt   <= GAP_M1;
            end else if (tick) begin
              if (cnt != '0) begin
                cnt <= cnt - 1'b1;
              end else begin
                state    <= go_tx ? ST_TX : ST_IDLE;
                chan_pos <= go_pos;
                if (go_tx) begin
                  cnt       <= air_m1;
                  tx_strobe <= 1'b1;
                  tx_is_rsp <= 1'b0;
                end
                if (!nxt[2]) pend <= 1'b0;
              end
            end
          end
          ST_GAP: begin
            if (tick) begin
              if (cnt != '0) begin
                cnt <= cnt - 1'b1;
              end else begin
                state     <= ST_RSP;
                cnt       <= air_m1;
                tx_strobe <= 1'b1;
                tx_is_rsp <= 1'b1;
              end
            end
          end
          ST_RSP: begin
            if (tick) begin
              if (cnt != '0) begin
                cnt <= cnt - 1'b1;
              end else begin
                state    <= go_tx ? ST_TX : ST_IDLE;
                chan_pos <= go_pos;
                if (go_tx) begin
                  cnt       <= air_m1;
                  tx_strobe <= 1'b1;
                  tx_is_rsp <= 1'b0;
                end
                if (!nxt[2]) pend <= 1'b0;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign event_active = (state != ST_IDLE);
  assign listen_win   = (state == ST_LISTEN);
endmodule

// File: rtl/adv_event_seq.sv
module adv_event_seq
  import adv_seq_pkg::*;
#(
  parameter int TICKS_PER_MS  = 1000,
  parameter int LISTEN_TICKS  = 300,
  parameter int RSP_GAP_TICKS = 150,
  parameter int OVH_BYTES     = 10,
  parameter int MAX_PAYLOAD   = 31,
  parameter int MIN_INTV      = 20,
  parameter int MAX_INTV      = 10240
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_us,
  input  logic        adv_en,
  input  logic        abort_evt,
  input  logic [2:0]  cfg_chan_mask,
  input  logic [13:0] cfg_interval_ms,
  input  logic [5:0]  cfg_payload_len,
  input  logic        cfg_scan_rsp_en,
  input  logic        rx_scan_req,
  output logic [5:0]  chan_idx,
  output logic        tx_strobe,
  output logic        tx_is_rsp,
  output logic        listen_win,
  output logic        event_active,
  output logic        cfg_err
);
  localparam int INTV_W = 14;
  localparam int LEN_W  = 6;
  localparam int MAX_AIR = (OVH_BYTES + (1 << LEN_W)) * 8;
  localparam int MAX_CNT = (MAX_AIR > LISTEN_TICKS) ?
                           ((MAX_AIR > RSP_GAP_TICKS) ? MAX_AIR : RSP_GAP_TICKS) :
                           ((LISTEN_TICKS > RSP_GAP_TICKS) ? LISTEN_TICKS : RSP_GAP_TICKS);
  localparam int CNT_W  = $clog2(MAX_CNT + 1);

  logic       start_evt;
  logic [1:0] chan_pos;

  adv_cfg_check #(
    .INTV_W(INTV_W), .LEN_W(LEN_W), .MAX_PAYLOAD(MAX_PAYLOAD),
    .MIN_INTV(MIN_INTV), .MAX_INTV(MAX_INTV)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .mask(cfg_chan_mask),
    .interval(cfg_interval_ms), .payload_len(cfg_payload_len),
    .cfg_err(cfg_err)
  );

  adv_interval_timer #(
    .TICKS_PER_MS(TICKS_PER_MS), .INTV_W(INTV_W)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick_us),
    .run(adv_en && !cfg_err), .interval(cfg_interval_ms),
    .start_evt(start_evt)
  );

  adv_event_fsm #(
    .LEN_W(LEN_W), .CNT_W(CNT_W), .OVH_BYTES(OVH_BYTES),
    .LISTEN_TICKS(LISTEN_TICKS), .RSP_GAP_TICKS(RSP_GAP_TICKS)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .tick(tick_us), .start_evt(start_evt),
    .kill(abort_evt || cfg_err), .mask(cfg_chan_mask),
    .payload_len(cfg_payload_len), .scan_en(cfg_scan_rsp_en),
    .rx_req(rx_scan_req), .chan_pos(chan_pos), .tx_strobe(tx_strobe),
    .tx_is_rsp(tx_is_rsp), .listen_win(listen_win),
    .event_active(event_active)
  );

  assign chan_idx = 6'(CH_BASE) + {4'd0, chan_pos};
endmodule

// File: rtl/adv_event_seq_chk.sv
module adv_event_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick_us,
  input logic        adv_en,
  input logic        abort_evt,
  input logic [2:0]  cfg_chan_mask,
  input logic [13:0] cfg_interval_ms,
  input logic [5:0]  cfg_payload_len,
  input logic        cfg_scan_rsp_en,
  input logic        rx_scan_req,
  input logic [5:0]  chan_idx,
  input logic        tx_strobe,
  input logic        tx_is_rsp,
  input logic        listen_win,
  input logic        event_active,
  input logic        cfg_err
);
  AST_STROBE_ON_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    tx_strobe |-> (chan_idx >= 6'd37 && chan_idx <= 6'd39 &&
                   cfg_chan_mask[2'(chan_idx - 6'd37)])); // R1
  AST_ERR_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> (!event_active && !tx_strobe)); // R4
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_strobe |=> !tx_strobe); // R5
  AST_LISTEN_NO_TX: assert property (@(posedge clk) disable iff (!rst_n)
    listen_win |-> (!tx_strobe && event_active)); // R6
  AST_RSP_SAME_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_strobe && tx_is_rsp) |-> $stable(chan_idx)); // R7
  AST_ABORT_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> !event_active); // R8
  AST_STROBE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_strobe |-> event_active); // R9
endmodule

bind adv_event_seq adv_event_seq_chk u_chk (.*);

// File: tb/adv_event_seq_test.sv
module adv_event_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int TPM    = 10;
  localparam int LISTEN = 40;
  localparam int GAP    = 150;
  localparam int OVH    = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_us = 1'b1;
  logic        adv_en = 1'b0;
  logic        abort_evt = 1'b0;
  logic [2:0]  cfg_chan_mask = 3'b111;
  logic [13:0] cfg_interval_ms = 14'd200;
  logic [5:0]  cfg_payload_len = 6'd0;
  logic        cfg_scan_rsp_en = 1'b0;
  logic        rx_scan_req = 1'b0;
  logic [5:0]  chan_idx;
  logic        tx_strobe, tx_is_rsp, listen_win, event_active, cfg_err;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int n_log = 0;
  int log_cyc [64];
  int log_ch  [64];
  int log_rsp [64];

  adv_event_seq #(
    .TICKS_PER_MS(TPM), .LISTEN_TICKS(LISTEN),
    .RSP_GAP_TICKS(GAP), .OVH_BYTES(OVH)
  ) uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (tx_strobe && n_log < 64) begin
      log_cyc[n_log] = cyc;
      log_ch[n_log]  = int'(chan_idx);
      log_rsp[n_log] = int'(tx_is_rsp);
      n_log = n_log + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic wait_to(input int c);
    int k = 0;
    while (cyc < c && k < 20000) begin step(); k++; end
  endtask

  task automatic wait_log(input int n);
    int k = 0;
    while (n_log < n && k < 5000) begin step(); k++; end
  endtask

  task automatic cleanup();
    adv_en = 1'b0;
    abort_evt = 1'b1;
    step();
    abort_evt = 1'b0;
    cfg_scan_rsp_en = 1'b0;
    repeat (3) step();
    n_log = 0;
  endtask

  task automatic setup(input logic [2:0] m, input int len, input int intv, input bit scan);
    cfg_chan_mask = m;
    cfg_payload_len = 6'(len);
    cfg_interval_ms = 14'(intv);
    cfg_scan_rsp_en = scan;
    repeat (2) step();
    n_log = 0;
    adv_en = 1'b1;
  endtask

  task automatic t_reset();
    chk(event_active == 1'b0, "R9 reset event_active", int'(event_active), 0);
    chk(tx_strobe == 1'b0, "R5 reset tx_strobe", int'(tx_strobe), 0);
    chk(cfg_err == 1'b0, "R4 reset cfg_err", int'(cfg_err), 0);
  endtask

  task automatic t_basic();
    int last;
    setup(3'b111, 5, 200, 1'b0);
    wait_log(3);
    chk(log_ch[0] == 37, "R1 first channel", log_ch[0], 37);
    chk(log_ch[1] == 38, "R1 second channel", log_ch[1], 38);
    chk(log_ch[2] == 39, "R1 third channel", log_ch[2], 39);
    chk(log_cyc[1] - log_cyc[0] == 120, "R5 airtime len5", log_cyc[1] - log_cyc[0], 120);
    chk(log_cyc[2] - log_cyc[1] == 120, "R5 airtime len5 b", log_cyc[2] - log_cyc[1], 120);
    last = log_cyc[2];
    wait_to(last + 119);
    chk(event_active == 1'b1, "R9 active in last packet", int'(event_active), 1);
    step();
    chk(event_active == 1'b0, "R9 falls after last packet", int'(event_active), 0);
    chk(n_log == 3, "R1 one strobe per channel", n_log, 3);
    cleanup();
  endtask

  task automatic t_subset();
    setup(3'b101, 0, 200, 1'b0);
    wait_log(2);
    chk(log_ch[0] == 37 && log_ch[1] == 39, "R1 mask 101 walk", log_ch[1], 39);
    chk(log_cyc[1] - log_cyc[0] == 80, "R5 airtime len0", log_cyc[1] - log_cyc[0], 80);
    cleanup();
    setup(3'b110, 0, 200, 1'b0);
    wait_log(2);
    chk(log_ch[0] == 38, "R2 lowest enabled first", log_ch[0], 38);
    chk(log_ch[1] == 39, "R1 mask 110 second", log_ch[1], 39);
    cleanup();
  endtask

  task automatic t_abort_restart();
    int f;
    setup(3'b111, 0, 100, 1'b0);
    wait_log(2);
    f = log_cyc[0];
    abort_evt = 1'b1;
    step();
    abort_evt = 1'b0;
    chk(event_active == 1'b0, "R8 abort closes event", int'(event_active), 1'b0);
    wait_to(f + 990);
    chk(n_log == 2, "R8 no strobe after abort", n_log, 2);
    wait_log(3);
    chk(log_ch[2] == 37, "R2 restart on first channel", log_ch[2], 37);
    chk(log_cyc[2] - f == 1000, "R3 interval 100ms", log_cyc[2] - f, 1000);
    cleanup();
  endtask

  task automatic t_interval();
    setup(3'b100, 0, 50, 1'b0);
    wait_log(3);
    chk(log_ch[0] == 39, "R1 mask 100 channel", log_ch[0], 39);
    chk(log_cyc[1] - log_cyc[0] == 500, "R3 interval 50ms a", log_cyc[1] - log_cyc[0], 500);
    chk(log_cyc[2] - log_cyc[1] == 500, "R3 interval 50ms b", log_cyc[2] - log_cyc[1], 500);
    cleanup();
  endtask

  task automatic t_listen();
    int f;
    setup(3'b011, 0, 200, 1'b1);
    wait_log(1);
    f = log_cyc[0];
    wait_to(f + 79);
    chk(listen_win == 1'b0, "R6 no window during packet", int'(listen_win), 0);
    wait_to(f + 100);
    chk(listen_win == 1'b1, "R6 window after packet", int'(listen_win), 1);
    wait_log(2);
    chk(log_ch[1] == 38, "R6 next channel after window", log_ch[1], 38);
    chk(log_cyc[1] - f == 80 + LISTEN, "R6 window length", log_cyc[1] - f, 80 + LISTEN);
    cleanup();
  endtask

  task automatic t_request();
    int er;
    int k = 0;
    setup(3'b011, 0, 200, 1'b1);
    while (!listen_win && k < 2000) begin step(); k++; end
    rx_scan_req = 1'b1;
    er = cyc + 1;
    step();
    rx_scan_req = 1'b0;
    wait_log(3);
    chk(log_rsp[1] == 1, "R7 response strobe kind", log_rsp[1], 1);
    chk(log_ch[1] == 37, "R7 response same channel", log_ch[1], 37);
    chk(log_cyc[1] == er + GAP, "R7 response 150 ticks", log_cyc[1] - er, GAP);
    chk(log_ch[2] == 38 && log_rsp[2] == 0, "R7 moves on after response", log_ch[2], 38);
    chk(log_cyc[2] - log_cyc[1] == 80, "R7 response airtime", log_cyc[2] - log_cyc[1], 80);
    cleanup();
  endtask

  task automatic t_pending();
    setup(3'b111, 0, 20, 1'b0);
    wait_log(4);
    chk(log_ch[3] == 37, "R10 held start on first channel", log_ch[3], 37);
    chk(log_cyc[3] - log_cyc[0] == 240, "R10 held start right after event",
        log_cyc[3] - log_cyc[0], 240);
    cleanup();
  endtask

  task automatic t_cfg();
    setup(3'b000, 0, 200, 1'b0);
    repeat (3) step();
    chk(cfg_err == 1'b1, "R4 zero mask", int'(cfg_err), 1);
    wait_to(cyc + 300);
    chk(n_log == 0, "R4 idle on zero mask", n_log, 0);
    adv_en = 1'b0;
    cfg_chan_mask = 3'b111; cfg_payload_len = 6'd32;
    repeat (2) step();
    chk(cfg_err == 1'b1, "R4 payload 32", int'(cfg_err), 1);
    cfg_payload_len = 6'd31; cfg_interval_ms = 14'd19;
    repeat (2) step();
    chk(cfg_err == 1'b1, "R4 interval 19", int'(cfg_err), 1);
    cfg_interval_ms = 14'd10241;
    repeat (2) step();
    chk(cfg_err == 1'b1, "R4 interval 10241", int'(cfg_err), 1);
    cfg_interval_ms = 14'd10240;
    repeat (2) step();
    chk(cfg_err == 1'b0, "R4 limits accepted", int'(cfg_err), 0);
    cleanup();
    setup(3'b111, 0, 200, 1'b0);
    wait_log(1);
    cfg_payload_len = 6'd40;
    repeat (3) step();
    chk(event_active == 1'b0, "R4 error closes event", int'(event_active), 0);
    cleanup();
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_basic();
    t_subset();
    t_abort_restart();
    t_interval();
    t_listen();
    t_request();
    t_pending();
    t_cfg();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule